// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Shifter

This block is a three-wire synchronous serial port for a small controller whose internal data bus is one nibble wide. The CPU loads one byte into an 8-bit shift register as two nibbles. It picks a clock source, an active edge and a bit order, and then sets a start bit. The block sends the byte on its serial output and, in the same transfer, collects one byte from its serial input. The CPU then reads that byte back as two nibbles.

In master mode the block makes the serial clock itself. It toggles the clock pin on every rising edge of one of three prescaler taps, and it holds an active-low chip-select low while the transfer runs. In slave mode the clock comes in on a pin. It is passed through a two-flop synchroniser and an edge detector, and a ready output stays high while the block is waiting for the eight external edges. The eighth active edge ends the transfer: it clears the start bit, sets a done status bit and raises an interrupt. Reading either data nibble clears the interrupt. When the port is disabled, every pin output enable is low.

Top module: `sync_serial_shifter`

## Requirements
- R1: When idle, a write to address 0 sets bits 3:0 of the shift register and a write to address 1 sets bits 7:4; reading those addresses returns the same nibbles. After reset, all four addresses read 0.
- R2: A transfer presents 8 bits on `sout_o` and captures 8 bits from `sin_i`, one bit on each active shift edge. After the transfer, the CPU reads the byte that the far end sent.
- R3: Control bit 1 (address 3) selects the bit order. With 1, the LSB goes out first and the first received bit lands in bit 0. With 0, the MSB goes out first and the first received bit lands in bit 7.
- R4: Control bit 0 (address 3) selects the active edge: 0 for rising, 1 for falling. In master mode `sclk_o` rests at the level equal to that bit whenever no transfer runs.
- R5: With config bit 2 (address 2) set to 1 (master), `sclk_o` toggles on each rising edge of the prescaler tap chosen by config bits 1:0. Code 0 selects tap 0, code 1 selects tap 1, and codes 2 and 3 select tap 2. Active edges are therefore two tap periods apart.
- R6: In slave mode (config bit 2 = 0), the register shifts once for each active edge seen on `sclk_i`. `csrdy_o` is high from start until the 8th edge and low otherwise.
- R7: In master mode, `csrdy_o` (chip-select) is low from start until the 8th shift and high otherwise.
- R8: On the 8th shift, the busy/start bit (address 3 read bit 3) clears, the done bit (address 3 read bit 2) sets, and `irq_o` rises.
- R9: Reading address 0 or address 1 clears `irq_o`.
- R10: Writing address 3 with bit 2 set aborts any transfer and clears the shift register, busy, done and `irq_o`.
- R11: Writes to addresses 0 and 1 while a transfer runs leave the shift register unchanged.
- R12: With config bit 3 (enable) at 0, all output enables are low, a running transfer is aborted, and a start request is ignored.
- R13: When enabled, `sout_oe` and `csrdy_oe` are high, and `sclk_oe` is high only in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe (clears the interrupt when reading data) |
| bus_addr | input | 2 | Register select: 0 data low, 1 data high, 2 config, 3 control/status |
| bus_wdata | input | 4 | CPU write nibble |
| bus_rdata | output | 4 | CPU read nibble |
| presc_taps | input | 3 | Three prescaler tap square waves |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |
| sout_oe | output | 1 | Output enable for serial data out |
| sclk_i | input | 1 | External serial clock (slave mode) |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe | output | 1 | Output enable for the clock pin |
| csrdy_o | output | 1 | Chip-select (master) or ready (slave) |
| csrdy_oe | output | 1 | Output enable for chip-select/ready |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The assertions check on every cycle that:
- completion always leaves busy low with done and the interrupt set;
- the interrupt rises only on completion;
- a disabled port never stays busy;
- the shift register holds still during a transfer unless a shift edge or a clear arrives, which covers the ignored data writes;
- the master clock rests at its idle level between transfers and never moves in slave mode.

Only the bench's scenarios can show the end-to-end results: that the exchanged bytes are right for each edge and bit order, that the spacing between active edges matches each prescaler tap code, and that the select/ready pin, the abort and the interrupt clear on read behave as required.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
    localparam int NIB_W     = 4;
    localparam int N_NIB     = 2;
    localparam int BYTE_W    = NIB_W * N_NIB;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int N_TAPS    = 3;
    localparam int TAP_SEL_W = $clog2(N_TAPS);
    localparam int ADDR_W    = 2;

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(3);

    typedef struct packed {
        logic                 en;
        logic                 master;
        logic [TAP_SEL_W-1:0] tap;
        logic                 lsb_first;
        logic                 edge_fall;
    } cfg_t;
endpackage

// File: rtl/ssh_regs.sv
module ssh_regs
    import ssh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NIB_W-1:0]  bus_wdata,
    input  logic [BYTE_W-1:0] shreg,
    input  logic              done_evt,
    output cfg_t              cfg,
    output logic              busy,
    output logic              start_p,
    output logic              clr_p,
    output logic [N_NIB-1:0]  ld,
    output logic              irq,
    output logic [NIB_W-1:0]  bus_rdata
);
    typedef struct packed {
        cfg_t cfg;
        logic busy;
        logic done;
        logic irq;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        start_p = 1'b0;
        clr_p   = 1'b0;
        ld      = '0;

        for (int i = 0; i < N_NIB; i++) begin
            ld[i] = bus_wr && !s_q.busy && (int'(bus_addr) == i);
        end

        if (bus_wr && bus_addr == A_CFG) begin
            s_d.cfg.en     = bus_wdata[3];
            s_d.cfg.master = bus_wdata[2];
            s_d.cfg.tap    = bus_wdata[TAP_SEL_W-1:0];
        end

        if (bus_wr && bus_addr == A_CTL) begin
            s_d.cfg.lsb_first = bus_wdata[1];
            s_d.cfg.edge_fall = bus_wdata[0];
            if (bus_wdata[2]) begin
                clr_p = 1'b1;
            end else if (bus_wdata[3] && s_q.cfg.en && !s_q.busy) begin
                start_p = 1'b1;
            end
        end

        if (bus_rd && int'(bus_addr) < N_NIB) begin
            s_d.irq = 1'b0;
        end

        if (done_evt) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.irq  = 1'b1;
        end

        if (start_p) begin
            s_d.busy = 1'b1;
            s_d.done = 1'b0;
        end

        if (clr_p) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b0;
            s_d.irq  = 1'b0;
        end

        if (!s_q.cfg.en) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_NIB; i++) begin
            if (int'(bus_addr) == i) begin
                bus_rdata = shreg[i*NIB_W +: NIB_W];
            end
        end
        if (bus_addr == A_CFG) begin
            bus_rdata = {s_q.cfg.en, s_q.cfg.master, s_q.cfg.tap};
        end
        if (bus_addr == A_CTL) begin
            bus_rdata = {s_q.busy, s_q.done, s_q.cfg.lsb_first, s_q.cfg.edge_fall};
        end
    end

    assign cfg  = s_q.cfg;
    assign busy = s_q.busy;
    assign irq  = s_q.irq;

    // R8
    done_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_evt && !clr_p) |=> (!s_q.busy && s_q.done && s_q.irq));

    // R8
    irq_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.irq) |-> $past(done_evt));

    // R12
    disabled_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cfg.en |=> !s_q.busy);
endmodule

// File: rtl/ssh_clk_src.sv
module ssh_clk_src
    import ssh_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 busy,
    input  logic                 master,
    input  logic                 edge_fall,
    input  logic [TAP_SEL_W-1:0] tap_sel,
    input  logic [N_TAPS-1:0]    presc_taps,
    input  logic                 sclk_i,
    output logic                 shift_en,
    output logic                 sclk_o
);
    typedef struct packed {
        logic [N_TAPS-1:0]      taps;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   phase;
    } state_t;

    state_t s_d, s_q;

    logic [N_TAPS-1:0]    rise;
    logic [TAP_SEL_W-1:0] sel;
    logic                 tap_rise;
    logic                 synced;
    logic                 slv_edge;
    logic                 m_toggle;

    always_comb begin
        s_d = s_q;

        rise     = presc_taps & ~s_q.taps;
        sel      = (int'(tap_sel) >= N_TAPS) ? TAP_SEL_W'(N_TAPS - 1) : tap_sel;
        tap_rise = rise[sel];

        synced   = s_q.sync[SYNC_STAGES-1];
        slv_edge = edge_fall ? (s_q.prev & ~synced) : (~s_q.prev & synced);

        s_d.taps = presc_taps;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], sclk_i};
        s_d.prev = synced;

        m_toggle = busy && master && tap_rise;

        if (!busy) begin
            s_d.phase = edge_fall;
        end else if (m_toggle) begin
            s_d.phase = ~s_q.phase;
        end

        if (master) begin
            shift_en = m_toggle && (s_q.phase == edge_fall);
        end else begin
            shift_en = busy && slv_edge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o = s_q.phase;

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sclk_o == $past(edge_fall)));

    // R6
    slave_clock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !master) |=> $stable(sclk_o));
endmodule

// File: rtl/ssh_shift_core.sv
module ssh_shift_core
    import ssh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              start_p,
    input  logic              clr_p,
    input  logic [N_NIB-1:0]  ld,
    input  logic [NIB_W-1:0]  wdata,
    input  logic              shift_en,
    input  logic              lsb_first,
    input  logic              sin_i,
    output logic [BYTE_W-1:0] sr_o,
    output logic              sout_o,
    output logic              done_evt
);
    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t s_d, s_q;
    logic   do_shift;

    always_comb begin
        s_d      = s_q;
        done_evt = 1'b0;
        do_shift = busy && shift_en;

        if (clr_p) begin
            s_d.sr  = '0;
            s_d.cnt = '0;
        end else if (start_p) begin
            s_d.cnt = '0;
        end else if (do_shift) begin
            if (lsb_first) begin
                s_d.sr = {sin_i, s_q.sr[BYTE_W-1:1]};
            end else begin
                s_d.sr = {s_q.sr[BYTE_W-2:0], sin_i};
            end
            s_d.cnt  = s_q.cnt + 1'b1;
            done_evt = (s_q.cnt == CNT_W'(BYTE_W - 1));
        end else begin
            for (int i = 0; i < N_NIB; i++) begin
                if (ld[i]) begin
                    s_d.sr[i*NIB_W +: NIB_W] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sr_o   = s_q.sr;
    assign sout_o = lsb_first ? s_q.sr[0] : s_q.sr[BYTE_W-1];

    // R11
    hold_in_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en && !clr_p) |=> $stable(sr_o));

    // R8
    done_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt |-> busy);
endmodule

// File: rtl/sync_serial_shifter.sv
module sync_serial_shifter
    import ssh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rdata,
    input  logic [N_TAPS-1:0] presc_taps,
    input  logic              sin_i,
    output logic              sout_o,
    output logic              sout_oe,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    output logic              csrdy_o,
    output logic              csrdy_oe,
    output logic              irq_o
);
    cfg_t              cfg;
    logic              busy;
    logic              start_p;
    logic              clr_p;
    logic [N_NIB-1:0]  ld;
    logic [BYTE_W-1:0] shreg;
    logic              done_evt;
    logic              shift_en;

    ssh_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .shreg     (shreg),
        .done_evt  (done_evt),
        .cfg       (cfg),
        .busy      (busy),
        .start_p   (start_p),
        .clr_p     (clr_p),
        .ld        (ld),
        .irq       (irq_o),
        .bus_rdata (bus_rdata)
    );

    ssh_clk_src #(.SYNC_STAGES(2)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .master     (cfg.master),
        .edge_fall  (cfg.edge_fall),
        .tap_sel    (cfg.tap),
        .presc_taps (presc_taps),
        .sclk_i     (sclk_i),
        .shift_en   (shift_en),
        .sclk_o     (sclk_o)
    );

    ssh_shift_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .start_p   (start_p),
        .clr_p     (clr_p),
        .ld        (ld),
        .wdata     (bus_wdata),
        .shift_en  (shift_en),
        .lsb_first (cfg.lsb_first),
        .sin_i     (sin_i),
        .sr_o      (shreg),
        .sout_o    (sout_o),
        .done_evt  (done_evt)
    );

    assign sout_oe  = cfg.en;
    assign csrdy_oe = cfg.en;
    assign sclk_oe  = cfg.en && cfg.master;
    assign csrdy_o  = cfg.master ? !busy : busy;
endmodule

// File: tb/sync_serial_shifter_tb_top.sv
module sync_serial_shifter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic [3:0] pcnt = '0;
    logic       sin_i = 1'b0;
    logic       sclk_i = 1'b0;
    logic       sout_o, sout_oe, sclk_o, sclk_oe, csrdy_o, csrdy_oe, irq_o;
    int         total = 0;
    int         fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) pcnt = pcnt + 1'b1;

    sync_serial_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .presc_taps(pcnt[3:1]), .sin_i(sin_i), .sout_o(sout_o), .sout_oe(sout_oe),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .csrdy_o(csrdy_o), .csrdy_oe(csrdy_oe), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic bitof(input logic [7:0] b, input bit lsb, input int i);
        return lsb ? b[i] : b[7-i];
    endfunction

    function automatic int exp_spacing(input logic [1:0] tap);
        return (tap >= 2) ? 32 : (8 << tap);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic run_xfer(input bit mst, input logic [7:0] txc, input logic [7:0] txe,
                            input bit lsb, input bit efall, input logic [1:0] tap, input bit junk);
        logic [7:0] rx_ext = '0;
        logic [3:0] lo, hi, st;
        int idx = 0, cyc = 0, last = 0;
        bit spfail = 0, jd = 0;
        logic psclk, psout;
        sclk_i = efall;
        wr(2'd2, {1'b1, mst, tap});
        wr(2'd3, {2'b00, lsb, efall});
        wr(2'd0, txc[3:0]);
        wr(2'd1, txc[7:4]);
        sin_i = bitof(txe, lsb, 0);
        chk("R13 sclk_oe follows mode", sclk_oe, mst);
        chk("R13 sout_oe/csrdy_oe on", {sout_oe, csrdy_oe}, 2'b11);
        if (mst) chk("R4 idle clock level", sclk_o, efall);
        chk("R6/R7 idle select/ready", csrdy_o, mst);
        wr(2'd3, {2'b10, lsb, efall});
        chk("R6/R7 active select/ready", csrdy_o, !mst);
        if (mst) begin
            psclk = sclk_o; psout = sout_o;
            while (idx < 8 && cyc < 4000) begin
                @(negedge clk);
                cyc++;
                bus_wr = 1'b0;
                if (junk && idx == 3 && !jd) begin
                    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ~txc[3:0]; jd = 1;
                end
                if (sclk_o != psclk && sclk_o != efall) begin
                    rx_ext = lsb ? {psout, rx_ext[7:1]} : {rx_ext[6:0], psout};
                    if (idx >= 1 && (cyc - last) != exp_spacing(tap)) spfail = 1;
                    last = cyc;
                    idx++;
                    if (idx < 8) sin_i = bitof(txe, lsb, idx);
                end
                psclk = sclk_o; psout = sout_o;
            end
            bus_wr = 1'b0;
            chk("R5 active edge spacing per tap", spfail, 1'b0);
            repeat (2) @(negedge clk);
            chk("R4 clock back to idle", sclk_o, efall);
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (junk && i == 3) wr(2'd1, ~txc[7:4]);
                else repeat (2) @(negedge clk);
                repeat (4) @(negedge clk);
                rx_ext = lsb ? {sout_o, rx_ext[7:1]} : {rx_ext[6:0], sout_o};
                sclk_i = !efall;
                repeat (6) @(negedge clk);
                sclk_i = efall;
                if (i < 7) sin_i = bitof(txe, lsb, i + 1);
            end
            repeat (6) @(negedge clk);
        end
        chk("R8 irq after 8th shift", irq_o, 1'b1);
        rd(2'd3, st);
        chk("R8 busy clear, done set", st[3:2], 2'b01);
        chk("R6/R7 select/ready released", csrdy_o, mst);
        rd(2'd0, lo);
        chk("R9 irq cleared by data read", irq_o, 1'b0);
        rd(2'd1, hi);
        chk("R2/R3/R11 byte received by cpu", {hi, lo}, txe);
        chk("R2/R3 byte sent to far end", rx_ext, txc);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [3:0] r;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk("R1 reset reads zero", r, 4'h0);
        end
        chk("R12 reset output enables off", {sout_oe, sclk_oe, csrdy_oe, irq_o}, 4'h0);

        // R1 nibble access when idle
        wr(2'd0, 4'h5); wr(2'd1, 4'hA);
        rd(2'd0, r); chk("R1 low nibble", r, 4'h5);
        rd(2'd1, r); chk("R1 high nibble", r, 4'hA);

        // R12 start ignored while disabled
        wr(2'd2, 4'b0100);
        wr(2'd3, 4'b1000);
        rd(2'd3, r); chk("R12 start ignored when disabled", r[3], 1'b0);
        chk("R12 enables off when disabled", {sout_oe, sclk_oe, csrdy_oe}, 3'b000);

        // R3 directed orders, R4 both edges, R5 every tap code
        run_xfer(1, 8'h01, 8'h80, 0, 0, 2'd0, 1);
        run_xfer(1, 8'h01, 8'h80, 1, 1, 2'd1, 0);
        run_xfer(1, 8'hC6, 8'h3B, 1, 0, 2'd2, 1);
        run_xfer(1, 8'h5A, 8'hE1, 0, 1, 2'd3, 0);
        run_xfer(0, 8'h81, 8'h7E, 0, 0, 2'd0, 1);
        run_xfer(0, 8'h81, 8'h7E, 1, 1, 2'd0, 1);

        // R10 clear aborts a running transfer
        wr(2'd2, 4'b1110);
        wr(2'd3, 4'b0000);
        wr(2'd0, 4'h3); wr(2'd1, 4'hC);
        wr(2'd3, 4'b1000);
        repeat (40) @(negedge clk);
        wr(2'd3, 4'b0100);
        rd(2'd3, r); chk("R10 clear drops busy and done", r[3:2], 2'b00);
        rd(2'd0, r); chk("R10 clear zeroes low nibble", r, 4'h0);
        rd(2'd1, r); chk("R10 clear zeroes high nibble", r, 4'h0);
        chk("R10 irq low after clear", irq_o, 1'b0);
        chk("R10 chip-select released", csrdy_o, 1'b1);

        // R12 disable aborts a running transfer
        wr(2'd3, 4'b1000);
        repeat (20) @(negedge clk);
        wr(2'd2, 4'b0110);
        repeat (2) @(negedge clk);
        rd(2'd3, r); chk("R12 disable aborts transfer", r[3], 1'b0);
        chk("R12 enables off after disable", {sout_oe, sclk_oe, csrdy_oe}, 3'b000);

        // random mix
        for (int n = 0; n < 24; n++) begin
            run_xfer($urandom % 2, 8'($urandom), 8'($urandom), $urandom % 2,
                     $urandom % 2, 2'($urandom), $urandom % 2);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule